// File: doc/BRIEF.md
# Serial Programming Target

This block sits inside a device and lets an external host program the on-chip flash and EEPROM over a four-wire serial link. Programming works only while the host holds the device's programming hold input active. The host clocks in instructions that are exactly four bytes long, most significant bit first. On each byte the block shifts back the byte it received just before. This lets the host check that both sides agree on where the byte boundaries are.

The host must first send an enable instruction. After that, flash words are collected byte by byte in a page buffer, and one instruction commits the whole page to the flash array. EEPROM bytes are written one instruction at a time. Any location can be read back. A write keeps the block busy for a programmable number of system clocks. During that time, reads of the page or EEPROM byte being written return 0xFF, so the host can poll until the stored value appears. Any instruction other than a read that arrives while the block is busy is dropped, and the error output reports it.

Top module: `serprog_target`

## Requirements
- R1: Instruction framing: the link is sampled on rising serial clock edges, MSB first, and every 8 bits form a byte. Every 4 bytes form an instruction: opcode, address high, address low, data. The fourth byte completes the instruction.
- R2: During each byte the block shifts out the byte it received just before. After reset or a hold release it shifts out 0x00. The only exception is the fourth byte of an enabled read.
- R3: Until an instruction 0xAC 0x53 x x completes, the block performs no action and raises no error. During that instruction's third byte the host receives 0x53 back.
- R4: While the programming hold input is low, the enabled state and the bit and byte counters are cleared, so after the hold returns high the block must be enabled again.
- R5: Opcode 0x40 writes the data byte into the low byte of page buffer word [address low mod page size]. Opcode 0x48 writes it into the high byte.
- R6: A high-byte load is accepted only if the low byte of that word was loaded since the last high-byte load or commit of that word. Otherwise it is dropped and the error output pulses.
- R7: Opcode 0x4C writes the whole buffer into the flash page selected by the upper address bits of {address high, address low}. The buffer then returns to 0xFFFF in every word, so words that were not loaded store 0xFFFF.
- R8: Opcode 0x20 returns the low byte of flash word {address high, address low} during byte four. Opcode 0x28 returns the high byte.
- R9: While a page write is busy, flash reads inside that page return 0xFF. Reads of other pages return the stored data.
- R10: Opcode 0xC0 replaces the EEPROM byte at the address with the data byte; no bits of the old value survive. Opcode 0xA0 reads a byte. While the write is busy, reads of that address return 0xFF.
- R11: A write lasts BUSY_CYCLES clocks. Any non-read instruction that completes during that time is dropped, and the error output pulses for one cycle.
- R12: An unknown opcode on an enabled block makes the error output pulse and changes nothing.
- R13: After reset, all flash words read 0xFFFF, all EEPROM bytes read 0xFF, and miso and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low power-on reset |
| progHold | input | 1 | High while the host holds the device in programming mode |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cmdError | output | 1 | One-cycle pulse when an instruction is rejected |

## Verification
The bench fills whole pages and the whole EEPROM with arithmetic patterns and reads every location back. A design that placed words in the wrong page, or that did not clear the buffer after a commit, would return wrong words in that sweep. The bench polls during a busy window, both inside and outside the page being written, and issues a load during busy. A design that leaked the stale value, blocked the wrong page, or kept the late load would show it when the page is later read. The bench also tests the byte ordering rule, the effect of the hold pin on enable and on the bit and byte counters, and writes sent before enable. A design that lost sync would return something other than 0x53 during the enable instruction's third byte.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam logic [7:0] OP_ENABLE     = 8'hAC;
  localparam logic [7:0] SYNC_BYTE     = 8'h53;
  localparam logic [7:0] OP_LOAD_LO    = 8'h40;
  localparam logic [7:0] OP_LOAD_HI    = 8'h48;
  localparam logic [7:0] OP_WRITE_PAGE = 8'h4C;
  localparam logic [7:0] OP_READ_LO    = 8'h20;
  localparam logic [7:0] OP_READ_HI    = 8'h28;
  localparam logic [7:0] OP_EE_WRITE   = 8'hC0;
  localparam logic [7:0] OP_EE_READ    = 8'hA0;

  typedef enum logic [1:0] {RD_NONE, RD_FLASH_LO, RD_FLASH_HI, RD_EE} rdKind_e;

  typedef struct packed {
    logic        loadLow;
    logic        loadHigh;
    logic        commitPage;
    logic        eeWrite;
    logic [15:0] addr;
    logic [7:0]  data;
  } strobe_t;

  function automatic rdKind_e readKindOf(input logic [7:0] op);
    case (op)
      OP_READ_LO: return RD_FLASH_LO;
      OP_READ_HI: return RD_FLASH_HI;
      OP_EE_READ: return RD_EE;
      default:    return RD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/serprog_ctrl.sv
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        progHold,
  input  logic        sclk,
  input  logic        mosi,
  output logic        miso,
  output strobe_t     stb,
  output rdKind_e     rdKind,
  output logic [15:0] rdAddr,
  input  logic [7:0]  rdByte,
  output logic        busyFlash,
  output logic        busyEe,
  output logic        ctrlErr
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [2:0] sclkSync;
  logic [1:0] mosiSync;
  logic       rise;
  logic       bitIn;
  logic [7:0] rx;
  logic [7:0] rxNext;
  logic [2:0] bitCnt;
  logic [1:0] byteIdx;
  logic [7:0] b0, b1, b2;
  logic [7:0] tx;
  logic       enabled;
  logic       byteDone;
  logic       execNow;
  logic [CW-1:0] busyCnt;
  logic       busyIsFlash;
  logic       busy;

  logic nLoadLo, nLoadHi, nCommit, nEeWr, nErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  assign rise     = sclkSync[1] & ~sclkSync[2];
  assign bitIn    = mosiSync[1];
  assign rxNext   = {rx[6:0], bitIn};
  assign byteDone = rise && (bitCnt == 3'd7);
  assign execNow  = byteDone && (byteIdx == 2'd3) && enabled;
  assign busy     = (busyCnt != '0);
  assign busyFlash = busy & busyIsFlash;
  assign busyEe    = busy & ~busyIsFlash;
  assign miso     = tx[7];

  // read lookup is presented as the third byte completes
  assign rdKind = (byteIdx == 2'd2) ? readKindOf(b0) : RD_NONE;
  assign rdAddr = {b1, rxNext};

  // serial shifter, byte framing and enable tracking
  always_ff @(posedge clk) begin
    if (!rstN || !progHold) begin
      rx      <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      b0      <= '0;
      b1      <= '0;
      b2      <= '0;
      tx      <= '0;
      enabled <= 1'b0;
    end else if (rise) begin
      rx     <= rxNext;
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        byteIdx <= byteIdx + 2'd1;
        case (byteIdx)
          2'd0: b0 <= rxNext;
          2'd1: b1 <= rxNext;
          2'd2: b2 <= rxNext;
          default: ;
        endcase
        if (byteIdx == 2'd2 && enabled && rdKind != RD_NONE) tx <= rdByte;
        else tx <= rxNext;
        if (byteIdx == 2'd3 && !enabled && b0 == OP_ENABLE && b1 == SYNC_BYTE)
          enabled <= 1'b1;
      end else begin
        tx <= {tx[6:0], 1'b0};
      end
    end
  end

  // instruction decode
  always_comb begin
    nLoadLo = 1'b0;
    nLoadHi = 1'b0;
    nCommit = 1'b0;
    nEeWr   = 1'b0;
    nErr    = 1'b0;
    if (execNow && readKindOf(b0) == RD_NONE) begin
      if (busy) begin
        nErr = 1'b1;
      end else begin
        case (b0)
          OP_ENABLE:     nErr = (b1 != SYNC_BYTE);
          OP_LOAD_LO:    nLoadLo = 1'b1;
          OP_LOAD_HI:    nLoadHi = 1'b1;
          OP_WRITE_PAGE: nCommit = 1'b1;
          OP_EE_WRITE:   nEeWr = 1'b1;
          default:       nErr = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !progHold) begin
      stb     <= '0;
      ctrlErr <= 1'b0;
    end else begin
      stb.loadLow    <= nLoadLo;
      stb.loadHigh   <= nLoadHi;
      stb.commitPage <= nCommit;
      stb.eeWrite    <= nEeWr;
      stb.addr       <= {b1, b2};
      stb.data       <= rxNext;
      ctrlErr        <= nErr;
    end
  end

  // busy timer survives a hold release: the write is already under way
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt     <= '0;
      busyIsFlash <= 1'b0;
    end else if (progHold && (nCommit || nEeWr)) begin
      busyCnt     <= CW'(BUSY_CYCLES);
      busyIsFlash <= nCommit;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/serprog_data.sv
module serprog_data
  import serprog_pkg::*;
#(
  parameter int FLASH_AW  = 10,
  parameter int PAGE_BITS = 7,
  parameter int EE_AW     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  rdKind_e     rdKind,
  input  logic [15:0] rdAddr,
  input  logic        busyFlash,
  input  logic        busyEe,
  output logic [7:0]  rdByte,
  output logic        orderErr
);
  localparam int PAGE_WORDS  = 1 << PAGE_BITS;
  localparam int FLASH_WORDS = 1 << FLASH_AW;
  localparam int EE_BYTES    = 1 << EE_AW;
  localparam int PAGE_AW     = FLASH_AW - PAGE_BITS;

  logic [PAGE_WORDS-1:0][15:0] bufAll;
  logic [PAGE_WORDS-1:0]       seenAll;
  logic [PAGE_BITS-1:0]        idx;
  logic [PAGE_AW-1:0]          cmtPage;
  logic [15:0] flashMem [FLASH_WORDS];
  logic [7:0]  eeMem [EE_BYTES];
  logic [PAGE_AW-1:0] busyPage;
  logic [EE_AW-1:0]   busyEeAddr;
  logic [15:0] rdWord;
  logic        inBusyPage;
  logic        atBusyEe;

  assign idx     = stb.addr[PAGE_BITS-1:0];
  assign cmtPage = stb.addr[FLASH_AW-1:PAGE_BITS];

  // one buffer slot per page word
  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    logic [15:0] word;
    logic        lowSeen;
    always_ff @(posedge clk) begin
      if (!rstN || stb.commitPage) begin
        word    <= 16'hFFFF;
        lowSeen <= 1'b0;
      end else if (stb.loadLow && idx == PAGE_BITS'(w)) begin
        word[7:0] <= stb.data;
        lowSeen   <= 1'b1;
      end else if (stb.loadHigh && idx == PAGE_BITS'(w) && lowSeen) begin
        word[15:8] <= stb.data;
        lowSeen    <= 1'b0;
      end
    end
    assign bufAll[w]  = word;
    assign seenAll[w] = lowSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) orderErr <= 1'b0;
    else       orderErr <= stb.loadHigh && !seenAll[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FLASH_WORDS; i++) flashMem[i] <= 16'hFFFF;
      busyPage <= '0;
    end else if (stb.commitPage) begin
      for (int i = 0; i < PAGE_WORDS; i++)
        flashMem[{cmtPage, PAGE_BITS'(i)}] <= bufAll[i];
      busyPage <= cmtPage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < EE_BYTES; i++) eeMem[i] <= 8'hFF;
      busyEeAddr <= '0;
    end else if (stb.eeWrite) begin
      eeMem[stb.addr[EE_AW-1:0]] <= stb.data;
      busyEeAddr <= stb.addr[EE_AW-1:0];
    end
  end

  assign rdWord     = flashMem[rdAddr[FLASH_AW-1:0]];
  assign inBusyPage = busyFlash && (rdAddr[FLASH_AW-1:PAGE_BITS] == busyPage);
  assign atBusyEe   = busyEe && (rdAddr[EE_AW-1:0] == busyEeAddr);

  always_comb begin
    case (rdKind)
      RD_FLASH_LO: rdByte = inBusyPage ? 8'hFF : rdWord[7:0];
      RD_FLASH_HI: rdByte = inBusyPage ? 8'hFF : rdWord[15:8];
      RD_EE:       rdByte = atBusyEe ? 8'hFF : eeMem[rdAddr[EE_AW-1:0]];
      default:     rdByte = 8'h00;
    endcase
  end
endmodule

// File: rtl/serprog_target.sv
module serprog_target
  import serprog_pkg::*;
#(
  parameter int FLASH_AW    = 10,
  parameter int PAGE_BITS   = 7,
  parameter int EE_AW       = 8,
  parameter int BUSY_CYCLES = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic progHold,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic cmdError
);
  strobe_t     stb;
  rdKind_e     rdKind;
  logic [15:0] rdAddr;
  logic [7:0]  rdByte;
  logic        busyFlash;
  logic        busyEe;
  logic        ctrlErr;
  logic        orderErr;

  serprog_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .progHold(progHold), .sclk(sclk), .mosi(mosi),
    .miso(miso), .stb(stb), .rdKind(rdKind), .rdAddr(rdAddr), .rdByte(rdByte),
    .busyFlash(busyFlash), .busyEe(busyEe), .ctrlErr(ctrlErr)
  );

  serprog_data #(.FLASH_AW(FLASH_AW), .PAGE_BITS(PAGE_BITS), .EE_AW(EE_AW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdKind(rdKind), .rdAddr(rdAddr),
    .busyFlash(busyFlash), .busyEe(busyEe), .rdByte(rdByte), .orderErr(orderErr)
  );

  assign cmdError = ctrlErr | orderErr;
endmodule

// File: rtl/serprog_checks.sv
module serprog_checks
  import serprog_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    progHold,
  input strobe_t stb,
  input logic    busyFlash,
  input logic    busyEe,
  input logic    ctrlErr,
  input logic    orderErr,
  input logic    cmdError
);
  // one action per instruction
  assert_one_action_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadLow, stb.loadHigh, stb.commitPage, stb.eeWrite}));

  assert_commit_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitPage |=> busyFlash);

  assert_eewrite_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.eeWrite |=> busyEe);

  assert_no_action_in_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadLow | stb.loadHigh | stb.commitPage | stb.eeWrite) |-> !$past(busyFlash | busyEe));

  assert_hold_silences_R4: assert property (@(posedge clk) disable iff (!rstN)
    !progHold |=> !(stb.loadLow | stb.loadHigh | stb.commitPage | stb.eeWrite | ctrlErr));

  assert_order_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |-> $past(stb.loadHigh));

  assert_error_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |=> !cmdError);
endmodule

bind serprog_target serprog_checks u_checks (
  .clk(clk), .rstN(rstN), .progHold(progHold), .stb(stb), .busyFlash(busyFlash),
  .busyEe(busyEe), .ctrlErr(ctrlErr), .orderErr(orderErr), .cmdError(cmdError)
);

// File: tb/serprog_target_bench.sv
module serprog_target_bench;
  localparam int FLASH_AW = 6;
  localparam int PAGE_BITS = 4;
  localparam int EE_AW = 4;
  localparam int BUSY = 400;
  localparam int HALF = 4;
  localparam int PW = 1 << PAGE_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progHold = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic cmdError;

  int checks = 0;
  int errors = 0;
  int errPulses = 0;
  bit done = 1'b0;
  logic [7:0] echo [4];

  always #2.5 clk = ~clk;

  serprog_target #(.FLASH_AW(FLASH_AW), .PAGE_BITS(PAGE_BITS), .EE_AW(EE_AW),
                   .BUSY_CYCLES(BUSY)) u_serprog_target (
    .clk(clk), .rstN(rstN), .progHold(progHold), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cmdError(cmdError)
  );

  always @(posedge clk) if (cmdError === 1'b1) errPulses++;

  function automatic logic [15:0] pat(input int a);
    logic [7:0] lo, hi;
    lo = 8'(a * 13 + 1);
    hi = 8'(a * 5) ^ 8'h3C;
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xferBit(input logic b, output logic got);
    @(negedge clk);
    mosi = b;
    repeat (HALF - 1) @(negedge clk);
    got = miso;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xferByte(input logic [7:0] o, output logic [7:0] got);
    for (int k = 7; k >= 0; k--) xferBit(o[k], got[k]);
  endtask

  task automatic sendCmd(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] d);
    logic [7:0] g;
    xferByte(a, g); echo[0] = g;
    xferByte(b, g); echo[1] = g;
    xferByte(c, g); echo[2] = g;
    xferByte(d, g); echo[3] = g;
    repeat (8) @(negedge clk);
  endtask

  task automatic waitBusy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  task automatic readFlash(input int a, input bit hi, output logic [7:0] v);
    sendCmd(hi ? 8'h28 : 8'h20, 8'(a >> 8), 8'(a), 8'h00);
    v = echo[3];
  endtask

  task automatic readEe(input int a, output logic [7:0] v);
    sendCmd(8'hA0, 8'h00, 8'(a), 8'h00);
    v = echo[3];
  endtask

  task automatic fillPage(input int p);
    for (int i = 0; i < PW; i++) begin
      logic [15:0] w;
      w = pat(p * PW + i);
      sendCmd(8'h40, 8'h00, 8'(i), w[7:0]);
      sendCmd(8'h48, 8'h00, 8'(i), w[15:8]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic g;
    int e0;
    repeat (10) @(negedge clk);
    // R13 reset state
    check("R13 miso after reset", {15'd0, miso}, 16'd0);
    check("R13 cmdError after reset", {15'd0, cmdError}, 16'd0);
    rstN = 1'b1;
    progHold = 1'b1;
    repeat (5) @(negedge clk);

    // R3 commands before enable are ignored silently
    e0 = errPulses;
    sendCmd(8'hC0, 8'h00, 8'h03, 8'h5A);
    sendCmd(8'h40, 8'h00, 8'h00, 8'h11);
    sendCmd(8'h4C, 8'h00, 8'h00, 8'h00);
    check("R3 no error before enable", 16'(errPulses - e0), 16'd0);

    // R1/R2/R3 enable and echo
    sendCmd(8'hAC, 8'h53, 8'h00, 8'h00);
    check("R2 echo byte1 is previous byte", {8'd0, echo[0]}, 16'h0000);
    check("R2 echo byte2 is opcode", {8'd0, echo[1]}, 16'h00AC);
    check("R3 R1 sync echo 0x53", {8'd0, echo[2]}, 16'h0053);
    check("R2 echo byte4", {8'd0, echo[3]}, 16'h0000);
    readEe(3, v);
    check("R3 pre-enable EEPROM write ignored", {8'd0, v}, 16'h00FF);
    readFlash(0, 1'b0, v);
    check("R13 R3 flash erased", {8'd0, v}, 16'h00FF);

    // R12 unknown opcode
    e0 = errPulses;
    sendCmd(8'h55, 8'h00, 8'h00, 8'h00);
    check("R12 unknown opcode error", 16'(errPulses - e0), 16'd1);

    // R5 R7 page fill, R9 polling
    fillPage(0);
    sendCmd(8'h4C, 8'h00, 8'h00, 8'h00);
    waitBusy();
    fillPage(1);
    sendCmd(8'h4C, 8'h00, 8'(PW), 8'h00);
    readFlash(PW + 3, 1'b0, v);
    check("R9 busy page reads 0xFF", {8'd0, v}, 16'h00FF);
    waitBusy();
    for (int a = 0; a < 2 * PW; a++) begin
      logic [7:0] lo, hi;
      readFlash(a, 1'b0, lo);
      readFlash(a, 1'b1, hi);
      check("R8 R5 R7 flash word", {hi, lo}, pat(a));
    end

    // R11 load during busy ignored, R7 buffer cleared after commit
    sendCmd(8'h4C, 8'h00, 8'(2 * PW), 8'h00);
    e0 = errPulses;
    sendCmd(8'h40, 8'h00, 8'h02, 8'h77);
    check("R11 load during busy flagged", 16'(errPulses - e0), 16'd1);
    waitBusy();
    for (int i = 0; i < PW; i++) begin
      logic [7:0] lo, hi;
      readFlash(2 * PW + i, 1'b0, lo);
      readFlash(2 * PW + i, 1'b1, hi);
      check("R7 empty buffer commits 0xFFFF", {hi, lo}, 16'hFFFF);
    end
    sendCmd(8'h4C, 8'h00, 8'(3 * PW), 8'h00);
    readFlash(7, 1'b0, v);
    check("R9 other page readable during busy", {8'd0, v}, {8'd0, pat(7) & 16'h00FF});
    waitBusy();
    readFlash(3 * PW + 2, 1'b0, v);
    check("R11 busy-time load left no trace", {8'd0, v}, 16'h00FF);

    // R6 byte order
    e0 = errPulses;
    sendCmd(8'h48, 8'h00, 8'h05, 8'h99);
    check("R6 high before low flagged", 16'(errPulses - e0), 16'd1);
    sendCmd(8'h40, 8'h00, 8'h05, 8'h21);
    sendCmd(8'h48, 8'h00, 8'h05, 8'h22);
    check("R6 ordered pair accepted", 16'(errPulses - e0), 16'd1);
    sendCmd(8'h48, 8'h00, 8'h05, 8'h33);
    check("R6 second high flagged", 16'(errPulses - e0), 16'd2);
    sendCmd(8'h40, 8'h00, 8'h06, 8'h44);
    sendCmd(8'h4C, 8'h00, 8'(2 * PW), 8'h00);
    waitBusy();
    begin
      logic [7:0] lo, hi;
      readFlash(2 * PW + 5, 1'b0, lo);
      readFlash(2 * PW + 5, 1'b1, hi);
      check("R6 word after ordered load", {hi, lo}, 16'h2221);
      readFlash(2 * PW + 6, 1'b0, lo);
      readFlash(2 * PW + 6, 1'b1, hi);
      check("R6 low-only word", {hi, lo}, 16'hFF44);
    end

    // R10 EEPROM
    for (int e = 0; e < (1 << EE_AW); e++) begin
      sendCmd(8'hC0, 8'h00, 8'(e), 8'(e * 17 + 2));
      if (e == 0) begin
        check("R2 echo of address byte", {8'd0, echo[3]}, 16'h0000);
        readEe(0, v);
        check("R10 busy EEPROM byte reads 0xFF", {8'd0, v}, 16'h00FF);
      end
      waitBusy();
    end
    for (int e = 0; e < (1 << EE_AW); e++) begin
      readEe(e, v);
      check("R10 EEPROM byte", {8'd0, v}, {8'd0, 8'(e * 17 + 2)});
    end
    sendCmd(8'hC0, 8'h00, 8'h04, 8'hB9);
    waitBusy();
    readEe(4, v);
    check("R10 overwrite replaces old value", {8'd0, v}, 16'h00B9);

    // R4 hold release clears enable and counters
    @(negedge clk); progHold = 1'b0;
    repeat (4) @(negedge clk); progHold = 1'b1;
    repeat (4) @(negedge clk);
    e0 = errPulses;
    sendCmd(8'hC0, 8'h00, 8'h04, 8'h00);
    check("R4 not enabled after hold release", 16'(errPulses - e0), 16'd0);
    xferBit(1'b1, g); xferBit(1'b0, g); xferBit(1'b1, g);
    @(negedge clk); progHold = 1'b0;
    repeat (4) @(negedge clk); progHold = 1'b1;
    repeat (4) @(negedge clk);
    sendCmd(8'hAC, 8'h53, 8'h00, 8'h00);
    check("R4 bit counter cleared, echo 0x00", {8'd0, echo[0]}, 16'h0000);
    check("R4 resync echo 0x53", {8'd0, echo[2]}, 16'h0053);
    readEe(4, v);
    check("R4 write while disabled ignored", {8'd0, v}, 16'h00B9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule